// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the pending-event flags of three timer/counters in one 8-bit status register. Each timer pulses an event input for one cycle. The pulse sets the matching flag on the next clock edge. The flag then holds until it is cleared.

There are two ways to clear a flag. The interrupt controller can pulse the per-source acknowledge input when it dispatches that source's vector. Software can also write a one to the flag's bit over the bus; writing zero does nothing.

The overflow flags of counters 1 and 2 follow the counting mode. In wrap mode they take the wraparound pulse. In up/down mode they take the pulse marking the direction reversal at the all-zero count. Each flag is ANDed with its enable bit and the global interrupt enable to form a per-source request line.

Top module: `timer_irq_flags`

## Requirements
- R1: An event pulse sets its flag at the next rising clock edge. The bit positions are: bit 6 counter2 overflow, bit 5 input capture, bit 4 compare A, bit 3 compare B, bit 2 counter1 overflow, bit 0 counter0 overflow.
- R2: A set flag keeps its value while no clear reaches it.
- R3: A bus write with a one in a flag's bit clears that flag at the next edge. A zero in a bit leaves that flag unchanged.
- R4: A one on `ack_i[b]` clears flag b only; all other flags are unaffected.
- R5: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R6: With `updown1_i`/`updown2_i` high, flag 2/6 is set only by the bottom-reversal pulse, and the wrap pulse is ignored. With it low, only the wrap pulse sets the flag, and the bottom-reversal pulse is ignored.
- R7: Bits 1 and 7 always read zero, whatever is written or acknowledged.
- R8: `irq_o[b]` is high in the same cycle exactly when `gie_i`, `ien_i[b]` and flag b are all high.
- R9: While `rst_ni` is low, every flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe for the flag register |
| wdata_i | input | 8 | Write data; a one in a bit clears that flag |
| rdata_o | output | 8 | Current flag register value |
| cap_evt_i | input | 1 | Counter1 capture-done pulse |
| cmpa_evt_i | input | 1 | Counter1 compare A match pulse |
| cmpb_evt_i | input | 1 | Counter1 compare B match pulse |
| ovf0_wrap_i | input | 1 | Counter0 wraparound pulse |
| ovf1_wrap_i | input | 1 | Counter1 wraparound pulse |
| ovf1_bottom_i | input | 1 | Counter1 reversal-at-zero pulse |
| updown1_i | input | 1 | Counter1 runs in up/down mode |
| ovf2_wrap_i | input | 1 | Counter2 wraparound pulse |
| ovf2_bottom_i | input | 1 | Counter2 reversal-at-zero pulse |
| updown2_i | input | 1 | Counter2 runs in up/down mode |
| ack_i | input | 8 | Per-source vector acknowledge pulses |
| ien_i | input | 8 | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 8 | Per-source interrupt requests |

## Verification
The bench builds the block with the package's default layout: an 8-bit register with six live flag positions and reserved bits 1 and 7. With this layout, writes and acknowledges aimed at the reserved positions can be applied and observed on the read port. Both up/down-capable overflow paths are reachable, so each mode can be driven with the wrong pulse to show it is ignored. The same-cycle set-and-clear case is covered for both clear paths.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned POS_OVF0 = 0;
  localparam int unsigned POS_OVF1 = 2;
  localparam int unsigned POS_CMPB = 3;
  localparam int unsigned POS_CMPA = 4;
  localparam int unsigned POS_CAP  = 5;
  localparam int unsigned POS_OVF2 = 6;
  localparam logic [REG_W-1:0] LIVE_MASK =
    REG_W'((1 << POS_OVF0) | (1 << POS_OVF1) | (1 << POS_CMPB) |
           (1 << POS_CMPA) | (1 << POS_CAP)  | (1 << POS_OVF2));
endpackage

// File: rtl/tif_flag_cell.sv
module tif_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority so a coincident event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/tif_ovf_sel.sv
module tif_ovf_sel (
  input  logic updown_i,
  input  logic wrap_i,
  input  logic bottom_i,
  output logic evt_o
);
  assign evt_o = updown_i ? bottom_i : wrap_i;
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import timer_irq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         cap_evt_i,
  input  logic         cmpa_evt_i,
  input  logic         cmpb_evt_i,
  input  logic         ovf0_wrap_i,
  input  logic         ovf1_wrap_i,
  input  logic         ovf1_bottom_i,
  input  logic         updown1_i,
  input  logic         ovf2_wrap_i,
  input  logic         ovf2_bottom_i,
  input  logic         updown2_i,
  input  logic [W-1:0] ack_i,
  input  logic [W-1:0] ien_i,
  input  logic         gie_i,
  output logic [W-1:0] irq_o
);
  localparam logic [W-1:0] MASK = W'(LIVE_MASK);

  logic         ovf1_evt, ovf2_evt;
  logic [W-1:0] set_vec, clr_vec, flags;

  tif_ovf_sel i_ovf1_sel (
    .updown_i (updown1_i),
    .wrap_i   (ovf1_wrap_i),
    .bottom_i (ovf1_bottom_i),
    .evt_o    (ovf1_evt)
  );

  tif_ovf_sel i_ovf2_sel (
    .updown_i (updown2_i),
    .wrap_i   (ovf2_wrap_i),
    .bottom_i (ovf2_bottom_i),
    .evt_o    (ovf2_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[POS_OVF0] = ovf0_wrap_i;
    set_vec[POS_OVF1] = ovf1_evt;
    set_vec[POS_CMPB] = cmpb_evt_i;
    set_vec[POS_CMPA] = cmpa_evt_i;
    set_vec[POS_CAP]  = cap_evt_i;
    set_vec[POS_OVF2] = ovf2_evt;
  end

  assign clr_vec = ({W{wr_en_i}} & wdata_i) | ack_i;

  // reserved positions: inputs absorbed, bit reads zero
  logic unused_rsvd;
  assign unused_rsvd = ^(clr_vec & set_vec & ~MASK);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_live
      tif_flag_cell i_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_vec[b]),
        .clr_i  (clr_vec[b]),
        .flag_o (flags[b])
      );
    end else begin : g_rsvd
      assign flags[b] = 1'b0;
    end
  end

  assign rdata_o = flags;
  assign irq_o   = flags & ien_i & {W{gie_i}};
endmodule

// File: rtl/timer_irq_flags_chk.sv
module timer_irq_flags_chk
  import timer_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             cap_evt_i,
  input logic             cmpa_evt_i,
  input logic             cmpb_evt_i,
  input logic             ovf0_wrap_i,
  input logic             ovf1_wrap_i,
  input logic             ovf1_bottom_i,
  input logic             updown1_i,
  input logic [REG_W-1:0] ack_i,
  input logic [REG_W-1:0] ien_i,
  input logic             gie_i,
  input logic [REG_W-1:0] irq_o
);
  AST_CAP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> rdata_o[POS_CAP]); // R1
  AST_CMPA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[POS_CMPA] && !(wr_en_i && wdata_i[POS_CMPA]) && !ack_i[POS_CMPA])
      |=> rdata_o[POS_CMPA]); // R2
  AST_WR1_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[POS_CMPB] && !cmpb_evt_i) |=> !rdata_o[POS_CMPB]); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[POS_OVF0] && !ovf0_wrap_i) |=> !rdata_o[POS_OVF0]); // R4
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpa_evt_i && (ack_i[POS_CMPA] || (wr_en_i && wdata_i[POS_CMPA])))
      |=> rdata_o[POS_CMPA]); // R5
  AST_UPDOWN_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (updown1_i && ovf1_wrap_i && !ovf1_bottom_i && !rdata_o[POS_OVF1])
      |=> !rdata_o[POS_OVF1]); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[1] && !rdata_o[7]); // R7
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~(rdata_o & ien_i)) == '0) && (gie_i || irq_o == '0)); // R8
  AST_IRQ_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && ien_i[POS_CAP] && rdata_o[POS_CAP]) |-> irq_o[POS_CAP]); // R8
endmodule

bind timer_irq_flags timer_irq_flags_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .cap_evt_i     (cap_evt_i),
  .cmpa_evt_i    (cmpa_evt_i),
  .cmpb_evt_i    (cmpb_evt_i),
  .ovf0_wrap_i   (ovf0_wrap_i),
  .ovf1_wrap_i   (ovf1_wrap_i),
  .ovf1_bottom_i (ovf1_bottom_i),
  .updown1_i     (updown1_i),
  .ack_i         (ack_i),
  .ien_i         (ien_i),
  .gie_i         (gie_i),
  .irq_o         (irq_o)
);

// File: tb/test_timer_irq_flags.sv
module test_timer_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cap = 1'b0, cmpa = 1'b0, cmpb = 1'b0;
  logic       ovf0 = 1'b0, ovf1 = 1'b0, bot1 = 1'b0, ud1 = 1'b0;
  logic       ovf2 = 1'b0, bot2 = 1'b0, ud2 = 1'b0;
  logic [7:0] ack = '0, ien = '0;
  logic       gie = 1'b0;
  logic [7:0] irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  timer_irq_flags i_timer_irq_flags (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .cap_evt_i(cap), .cmpa_evt_i(cmpa), .cmpb_evt_i(cmpb), .ovf0_wrap_i(ovf0),
    .ovf1_wrap_i(ovf1), .ovf1_bottom_i(bot1), .updown1_i(ud1),
    .ovf2_wrap_i(ovf2), .ovf2_bottom_i(bot2), .updown2_i(ud2),
    .ack_i(ack), .ien_i(ien), .gie_i(gie), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] evt;
    logic       wr;
    logic [7:0] wd;
    logic [7:0] ak;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h20, 1'b0, 8'h00, 8'h00, 8'h20},  // R1 capture
    '{8'h18, 1'b0, 8'h00, 8'h00, 8'h38},  // R1 compares
    '{8'h45, 1'b0, 8'h00, 8'h00, 8'h7D},  // R1 overflows
    '{8'h00, 1'b0, 8'h00, 8'h00, 8'h7D},  // R2 hold
    '{8'h00, 1'b1, 8'h00, 8'h00, 8'h7D},  // R3 zero write
    '{8'h00, 1'b1, 8'h82, 8'h00, 8'h7D},  // R7 reserved write
    '{8'h00, 1'b1, 8'h30, 8'h00, 8'h4D},  // R3 clear
    '{8'h00, 1'b0, 8'h00, 8'h08, 8'h45},  // R4 ack one
    '{8'h00, 1'b0, 8'h00, 8'h41, 8'h04},  // R4 ack two
    '{8'h04, 1'b1, 8'h04, 8'h00, 8'h04},  // R5 set vs write
    '{8'h10, 1'b0, 8'h00, 8'h10, 8'h14},  // R5 set vs ack
    '{8'h00, 1'b1, 8'hFF, 8'h00, 8'h00},  // R3 clear all
    '{8'h01, 1'b0, 8'h00, 8'hFF, 8'h01}   // R5 R7 ack all
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive_evt(logic [7:0] e);
    ovf0 = e[0]; ovf1 = e[2]; cmpb = e[3]; cmpa = e[4]; cap = e[5]; ovf2 = e[6];
  endtask

  task automatic idle();
    drive_evt('0); wr_en = 1'b0; wdata = '0; ack = '0; bot1 = 1'b0; bot2 = 1'b0;
  endtask

  // drive at negedge, one posedge, check at next negedge
  task automatic step(logic [7:0] e, logic w, logic [7:0] wd, logic [7:0] a,
                      logic b1, logic b2);
    drive_evt(e); wr_en = w; wdata = wd; ack = a; bot1 = b1; bot2 = b2;
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #3;
    check("R9 reset flags", rdata, 8'h00);
    check("R9 reset irq", irq, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].evt, VECS[i].wr, VECS[i].wd, VECS[i].ak, 1'b0, 1'b0);
      check($sformatf("R1-vec%0d", i), rdata, VECS[i].exp);
    end

    // R6 counter1 up/down
    step('0, 1'b1, 8'hFF, '0, 1'b0, 1'b0);
    ud1 = 1'b1; ud2 = 1'b1;
    step(8'h44, 1'b0, '0, '0, 1'b0, 1'b0);
    check("R6 wrap ignored in updown", rdata, 8'h00);
    step('0, 1'b0, '0, '0, 1'b1, 1'b0);
    check("R6 bottom sets ovf1", rdata, 8'h04);
    step('0, 1'b0, '0, '0, 1'b0, 1'b1);
    check("R6 bottom sets ovf2", rdata, 8'h44);
    ud1 = 1'b0; ud2 = 1'b0;
    step('0, 1'b1, 8'hFF, '0, 1'b1, 1'b1);
    check("R6 bottom ignored in wrap mode", rdata, 8'h00);
    step(8'h40, 1'b0, '0, '0, 1'b0, 1'b0);
    check("R6 wrap sets ovf2", rdata, 8'h40);

    // R8 request gating
    step(8'h39, 1'b0, '0, '0, 1'b0, 1'b0);
    check("R8 flags", rdata, 8'h79);
    ien = 8'h21; gie = 1'b0; #1;
    check("R8 gie low", irq, 8'h00);
    gie = 1'b1; #1;
    check("R8 partial enable", irq, 8'h21);
    ien = 8'hFF; #1;
    check("R8 full enable", irq, 8'h79);
    step('0, 1'b0, '0, 8'h20, 1'b0, 1'b0);
    check("R8 ack drops request", irq, 8'h59);

    // R9 reset in operation
    rst_n = 1'b0; #1;
    check("R9 mid-run reset", rdata, 8'h00);
    check("R9 mid-run irq", irq, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 stays clear after reset", rdata, 8'h00);

    summary();
  end
endmodule